// File: doc/BRIEF.md
# Return-Stack Branch Message Filter

This block sits in an instruction-trace encoder and looks at the stream of retired-instruction records. A record arrives on any cycle where `in_valid` is high. Each record carries a 4-bit instruction-type code, the instruction address and a flag that marks a compressed (2-byte) instruction. The block decides when an indirect-branch message must go out. Such a message carries the actual destination address, which is the address of the next valid record.

Calls push a return address onto a small circular return-address stack. Function returns and co-routine swaps pop that stack. Their message is suppressed when the popped prediction equals the address that actually follows. Because the destination is only known when the next valid record arrives, every message decision is deferred to that record. Cycles with `in_valid` low are ignored in between.

Top module: `rs_branch_filter`

## Requirements
- R1: After reset `msg_valid` is low, the stack is empty and no decision is pending.
- R2: Type code 8 (indirect call) pushes a return address. It also produces a message whose target is the address of the next valid record.
- R3: Type code 9 (direct call) pushes a return address and produces no message.
- R4: Type code 13 (function return) pops the stack. A message is produced on the next valid record only if the popped address differs from that record's address.
- R5: Type code 12 (co-routine swap) pops the stack, then pushes its own return address. It produces a message only if the popped address differs from the next valid record's address.
- R6: Type codes 10 and 14 (indirect jumps) always produce a message on the next valid record, and both leave the stack unchanged.
- R7: Type codes 11 and 15 (direct jumps) produce no message and leave the stack unchanged.
- R8: A cycle with `in_valid` low never resolves a pending decision, whatever its address. Resolution waits for the next valid record.
- R9: The pushed return address is the record address plus 2 when `in_compressed` is 1, and plus 4 when it is 0.
- R10: The stack holds `DEPTH` entries. A push onto a full stack discards the oldest entry.
- R11: A return or swap that pops an empty stack always produces a message.
- R12: `msg_valid` is a one-cycle pulse in the cycle after the resolving record, with `msg_target` equal to that record's address. Type codes 0 to 7 produce no message and leave the stack unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Record present this cycle |
| in_itype | input | 4 | Instruction type code of the record |
| in_addr | input | AW | Address of the retired instruction |
| in_compressed | input | 1 | 1 = 2-byte instruction, 0 = 4-byte |
| msg_valid | output | 1 | Indirect-branch message strobe |
| msg_target | output | AW | Destination address carried by the message |

## Verification
The bench drives calls followed by returns whose next address either matches or misses the prediction. A design that compared against the wrong stack entry, or added the wrong instruction length, would emit messages on correctly predicted returns or stay silent on wrong ones. Idle gaps carrying misleading addresses are placed between a return and its destination. A design that resolved on an invalid cycle would compare against garbage and fire early or not at all. Jumps are interleaved between calls and returns to expose any stray stack movement. A run of pushes longer than the stack is unwound to its end: a design that dropped the newest entry, or failed to treat an empty pop as a miss, would show the wrong result on the last return.

// File: rtl/rsf_pkg.sv
package rsf_pkg;
  typedef enum logic [1:0] {
    PEND_NONE  = 2'd0,
    PEND_EMIT  = 2'd1,
    PEND_CHECK = 2'd2
  } pend_e;

  localparam logic [3:0] IT_ICALL    = 4'd8;
  localparam logic [3:0] IT_DCALL    = 4'd9;
  localparam logic [3:0] IT_IJMP     = 4'd10;
  localparam logic [3:0] IT_DJMP     = 4'd11;
  localparam logic [3:0] IT_SWAP     = 4'd12;
  localparam logic [3:0] IT_RET      = 4'd13;
  localparam logic [3:0] IT_IJMP_LNK = 4'd14;
  localparam logic [3:0] IT_DJMP_LNK = 4'd15;

  typedef struct packed {
    logic  push;
    logic  pop;
    pend_e kind;
  } act_t;
endpackage

// File: rtl/rsf_classify.sv
module rsf_classify
  import rsf_pkg::*;
(
  input  logic [3:0] itype,
  output act_t       act
);
  always_comb begin
    act = '{push: 1'b0, pop: 1'b0, kind: PEND_NONE};
    case (itype)
      IT_ICALL:               act = '{push: 1'b1, pop: 1'b0, kind: PEND_EMIT};
      IT_DCALL:               act = '{push: 1'b1, pop: 1'b0, kind: PEND_NONE};
      IT_IJMP, IT_IJMP_LNK:   act = '{push: 1'b0, pop: 1'b0, kind: PEND_EMIT};
      IT_DJMP, IT_DJMP_LNK:   act = '{push: 1'b0, pop: 1'b0, kind: PEND_NONE};
      IT_SWAP:                act = '{push: 1'b1, pop: 1'b1, kind: PEND_CHECK};
      IT_RET:                 act = '{push: 1'b0, pop: 1'b1, kind: PEND_CHECK};
      default:                act = '{push: 1'b0, pop: 1'b0, kind: PEND_NONE};
    endcase
  end
endmodule

// File: rtl/rsf_stack.sv
module rsf_stack #(
  parameter int AW    = 32,
  parameter int DEPTH = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic          pop,
  input  logic [AW-1:0] wdata,
  output logic [AW-1:0] top_data,
  output logic          empty
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);
  localparam logic [CW-1:0] FULL = CW'(DEPTH);

  logic [AW-1:0] mem [DEPTH];
  logic [PW-1:0] ptr_q, ptr_d, ptr_inc, ptr_dec, wr_idx;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          wr_en;

  assign ptr_inc  = (ptr_q == LAST) ? '0 : ptr_q + 1'b1;
  assign ptr_dec  = (ptr_q == '0) ? LAST : ptr_q - 1'b1;
  assign empty    = (cnt_q == '0);
  assign top_data = mem[ptr_q];

  always_comb begin
    ptr_d  = ptr_q;
    cnt_d  = cnt_q;
    wr_en  = 1'b0;
    wr_idx = ptr_inc;
    if (push && pop && !empty) begin
      wr_en  = 1'b1;
      wr_idx = ptr_q;
    end else if (push) begin
      wr_en  = 1'b1;
      wr_idx = ptr_inc;
      ptr_d  = ptr_inc;
      cnt_d  = (cnt_q == FULL) ? cnt_q : cnt_q + 1'b1;
    end else if (pop && !empty) begin
      ptr_d  = ptr_dec;
      cnt_d  = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= '0;
      cnt_q <= '0;
    end else begin
      ptr_q <= ptr_d;
      cnt_q <= cnt_d;
    end
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_entry
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        mem[i] <= '0;
      else if (wr_en && (wr_idx == PW'(i)))
        mem[i] <= wdata;
    end
  end
endmodule

// File: rtl/rs_branch_filter.sv
module rs_branch_filter
  import rsf_pkg::*;
#(
  parameter int AW    = 32,
  parameter int DEPTH = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [3:0]    in_itype,
  input  logic [AW-1:0] in_addr,
  input  logic          in_compressed,
  output logic          msg_valid,
  output logic [AW-1:0] msg_target
);
  localparam logic [AW-1:0] LEN_C = AW'(2);
  localparam logic [AW-1:0] LEN_F = AW'(4);

  act_t          act;
  logic [AW-1:0] ret_addr, stk_top;
  logic          stk_empty;

  pend_e         pend_q, pend_d;
  logic [AW-1:0] pred_q, pred_d;
  logic          pred_ok_q, pred_ok_d;
  logic          mv_q, mv_d;
  logic [AW-1:0] tgt_q, tgt_d;
  logic          fire;

  rsf_classify u_cls (
    .itype (in_itype),
    .act   (act)
  );

  assign ret_addr = in_addr + (in_compressed ? LEN_C : LEN_F);

  rsf_stack #(.AW(AW), .DEPTH(DEPTH)) u_stk (
    .clk      (clk),
    .rst_n    (rst_n),
    .push     (in_valid && act.push),
    .pop      (in_valid && act.pop),
    .wdata    (ret_addr),
    .top_data (stk_top),
    .empty    (stk_empty)
  );

  always_comb begin
    fire = (pend_q == PEND_EMIT) ||
           ((pend_q == PEND_CHECK) && (!pred_ok_q || (pred_q != in_addr)));
    pend_d    = pend_q;
    pred_d    = pred_q;
    pred_ok_d = pred_ok_q;
    mv_d      = 1'b0;
    tgt_d     = tgt_q;
    if (in_valid) begin
      mv_d      = fire;
      tgt_d     = fire ? in_addr : tgt_q;
      pend_d    = act.kind;
      pred_d    = stk_top;
      pred_ok_d = !stk_empty;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q    <= PEND_NONE;
      pred_q    <= '0;
      pred_ok_q <= 1'b0;
      mv_q      <= 1'b0;
      tgt_q     <= '0;
    end else begin
      pend_q    <= pend_d;
      pred_q    <= pred_d;
      pred_ok_q <= pred_ok_d;
      mv_q      <= mv_d;
      tgt_q     <= tgt_d;
    end
  end

  assign msg_valid  = mv_q;
  assign msg_target = tgt_q;
endmodule

// File: rtl/rs_branch_filter_chk.sv
module rs_branch_filter_chk
  import rsf_pkg::*;
#(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic [3:0]    in_itype,
  input logic [AW-1:0] in_addr,
  input logic          in_compressed,
  input logic          msg_valid,
  input logic [AW-1:0] msg_target,
  input pend_e         pend,
  input logic          stk_empty,
  input logic [AW-1:0] stk_top
);
  a_r8_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !msg_valid);

  a_r12_target: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid |-> (msg_target == $past(in_addr)));

  a_r6_emit_fires: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && pend == PEND_EMIT) |=> msg_valid);

  a_r7_none_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && pend == PEND_NONE) |=> !msg_valid);

  a_r9_push_addr: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_itype == 4'd9) |=>
      (!stk_empty && stk_top == ($past(in_addr) + ($past(in_compressed) ? AW'(2) : AW'(4)))));

  a_r4_ret_defers: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_itype == 4'd13) |=> (pend == PEND_CHECK && !msg_valid || pend == PEND_CHECK));
endmodule

bind rs_branch_filter rs_branch_filter_chk #(.AW(AW)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .in_valid      (in_valid),
  .in_itype      (in_itype),
  .in_addr       (in_addr),
  .in_compressed (in_compressed),
  .msg_valid     (msg_valid),
  .msg_target    (msg_target),
  .pend          (pend_q),
  .stk_empty     (stk_empty),
  .stk_top       (stk_top)
);

// File: tb/rs_branch_filter_test.sv
module rs_branch_filter_test;
  localparam int CLK_PERIOD = 10;
  localparam int AW         = 32;
  localparam int DEPTH      = 8;

  logic          clk;
  logic          rst_n;
  logic          in_valid;
  logic [3:0]    in_itype;
  logic [AW-1:0] in_addr;
  logic          in_compressed;
  logic          msg_valid;
  logic [AW-1:0] msg_target;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  rs_branch_filter #(.AW(AW), .DEPTH(DEPTH)) uut (
    .clk           (clk),
    .rst_n         (rst_n),
    .in_valid      (in_valid),
    .in_itype      (in_itype),
    .in_addr       (in_addr),
    .in_compressed (in_compressed),
    .msg_valid     (msg_valid),
    .msg_target    (msg_target)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic step(input logic v, input logic [3:0] it, input logic [AW-1:0] a, input logic c);
    @(negedge clk);
    in_valid      = v;
    in_itype      = it;
    in_addr       = a;
    in_compressed = c;
    @(posedge clk);
    #1;
  endtask

  task automatic rec(input logic [3:0] it, input logic [AW-1:0] a, input logic c);
    step(1'b1, it, a, c);
  endtask

  task automatic idle(input logic [AW-1:0] a);
    step(1'b0, 4'd13, a, 1'b0);
  endtask

  task automatic chk(input logic exp_mv, input logic [AW-1:0] exp_t, input string tag);
    checks++;
    if (msg_valid !== exp_mv || (exp_mv && msg_target !== exp_t)) begin
      errors++;
      $display("FAIL %s: msg_valid=%0b msg_target=%h expected msg_valid=%0b msg_target=%h",
               tag, msg_valid, msg_target, exp_mv, exp_t);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    in_valid = 1'b0;
    in_itype = '0;
    in_addr = '0;
    in_compressed = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic t_reset();
    do_reset();
    #1;
    chk(1'b0, '0, "R1 idle after reset");
    rec(4'd13, 32'h40, 1'b0);
    chk(1'b0, '0, "R1 return waits");
    rec(4'd0, 32'h80, 1'b0);
    chk(1'b1, 32'h80, "R11 empty pop after reset");
  endtask

  task automatic t_call_ret();
    rec(4'd9, 32'h100, 1'b0);
    chk(1'b0, '0, "R3 direct call silent");
    rec(4'd0, 32'h2000, 1'b0);
    chk(1'b0, '0, "R3 call target silent");
    rec(4'd13, 32'h2004, 1'b0);
    rec(4'd0, 32'h104, 1'b0);
    chk(1'b0, '0, "R4 matched return suppressed");
  endtask

  task automatic t_len();
    rec(4'd9, 32'h100, 1'b1);
    rec(4'd13, 32'h300, 1'b0);
    rec(4'd0, 32'h104, 1'b0);
    chk(1'b1, 32'h104, "R4 R9 mismatch with compressed length");
    rec(4'd9, 32'h120, 1'b1);
    rec(4'd13, 32'h300, 1'b0);
    rec(4'd0, 32'h122, 1'b0);
    chk(1'b0, '0, "R9 compressed return matches");
  endtask

  task automatic t_icall();
    rec(4'd8, 32'h300, 1'b0);
    chk(1'b0, '0, "R2 waits for target");
    rec(4'd0, 32'h1000, 1'b0);
    chk(1'b1, 32'h1000, "R2 indirect call message");
    rec(4'd13, 32'h1010, 1'b0);
    chk(1'b0, '0, "R12 pulse lasts one cycle");
    rec(4'd0, 32'h304, 1'b0);
    chk(1'b0, '0, "R2 return address pushed");
  endtask

  task automatic t_ijmp();
    rec(4'd9, 32'h400, 1'b0);
    rec(4'd10, 32'h500, 1'b0);
    rec(4'd14, 32'h600, 1'b0);
    chk(1'b1, 32'h600, "R6 itype 10 message");
    rec(4'd13, 32'h700, 1'b0);
    chk(1'b1, 32'h700, "R6 itype 14 message");
    rec(4'd0, 32'h404, 1'b0);
    chk(1'b0, '0, "R6 stack untouched");
  endtask

  task automatic t_djmp();
    rec(4'd9, 32'h800, 1'b1);
    rec(4'd11, 32'h900, 1'b0);
    chk(1'b0, '0, "R7 itype 11 silent");
    rec(4'd15, 32'hA00, 1'b0);
    chk(1'b0, '0, "R7 itype 15 silent");
    rec(4'd5, 32'hB00, 1'b0);
    chk(1'b0, '0, "R12 other itype silent");
    rec(4'd13, 32'hB04, 1'b0);
    chk(1'b0, '0, "R12 other itype silent next");
    rec(4'd0, 32'h802, 1'b0);
    chk(1'b0, '0, "R7 R12 stack untouched");
  endtask

  task automatic t_swap();
    rec(4'd9, 32'hC00, 1'b0);
    rec(4'd12, 32'hD00, 1'b0);
    rec(4'd0, 32'hC04, 1'b0);
    chk(1'b0, '0, "R5 swap match suppressed");
    rec(4'd13, 32'hC08, 1'b0);
    rec(4'd0, 32'hD04, 1'b0);
    chk(1'b0, '0, "R5 swap pushed own return");
    rec(4'd9, 32'hE00, 1'b0);
    rec(4'd12, 32'hF00, 1'b0);
    rec(4'd0, 32'h1234, 1'b0);
    chk(1'b1, 32'h1234, "R5 swap mismatch");
    rec(4'd13, 32'h1238, 1'b0);
    rec(4'd0, 32'hF04, 1'b0);
    chk(1'b0, '0, "R5 swap mismatch still pushed");
  endtask

  task automatic t_gap();
    rec(4'd9, 32'h1400, 1'b0);
    rec(4'd13, 32'h1500, 1'b0);
    idle(32'h9999);
    chk(1'b0, '0, "R8 invalid garbage ignored");
    idle(32'hDEAD);
    chk(1'b0, '0, "R8 second invalid ignored");
    rec(4'd0, 32'h1404, 1'b0);
    chk(1'b0, '0, "R8 match after gap");
    rec(4'd10, 32'h1600, 1'b0);
    idle(32'h1700);
    chk(1'b0, '0, "R8 no emit on invalid");
    rec(4'd0, 32'h1800, 1'b0);
    chk(1'b1, 32'h1800, "R8 emit on next valid");
    rec(4'd9, 32'h1A00, 1'b0);
    rec(4'd13, 32'h1B00, 1'b0);
    idle(32'h1A04);
    chk(1'b0, '0, "R8 invalid matching address not used");
    rec(4'd0, 32'h5555, 1'b0);
    chk(1'b1, 32'h5555, "R8 mismatch resolved on valid");
  endtask

  task automatic t_overflow();
    do_reset();
    for (int k = 0; k <= DEPTH; k++) rec(4'd9, 32'h2000 + 32'(k) * 32'h100, 1'b0);
    rec(4'd13, 32'h3000, 1'b0);
    for (int k = DEPTH; k >= 1; k--) begin
      rec(4'd13, 32'h2000 + 32'(k) * 32'h100 + 32'h4, 1'b0);
      chk(1'b0, '0, "R10 newest entries kept");
    end
    rec(4'd0, 32'h2004, 1'b0);
    chk(1'b1, 32'h2004, "R10 R11 oldest dropped then empty pop");
  endtask

  initial begin
    rst_n = 1'b0;
    in_valid = 1'b0;
    in_itype = '0;
    in_addr = '0;
    in_compressed = 1'b0;
    t_reset();
    t_call_ret();
    t_len();
    t_icall();
    t_ijmp();
    t_djmp();
    t_swap();
    t_gap();
    t_overflow();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: run hung, actual=timeout expected=completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule